// File: doc/BRIEF.md
# Pipelined Binary32 Floating-Point Multiplier

This block multiplies two binary32 floating-point operands and returns their binary32 product two clock cycles later. The only rounding mode is round-to-nearest with ties going to the even value. Each operand is laid out with the sign in the most significant bit, the biased exponent in the next EXP_W bits, and the fraction in the low FRAC_W bits. Every operand is split into those fields. A normal operand gets its implicit leading one back. The two significands are multiplied into a double-width product, the exponents are added and the bias is taken off once. The product is then normalized, rounded with a guard bit and a sticky bit, normalized again when rounding overflows the significand, and packed.

A word presented with `in_valid` high is captured at the next rising edge. The first stage splits the fields, decides the special cases and forms the significand product. The second stage normalizes, rounds and packs. One new operation can start every cycle. The exponent and fraction widths are parameters. A small format (4-bit exponent, 3-bit fraction) gives the same behaviour and is used for exhaustive sweeps. The significand multiplier is built either from radix-4 recoded partial products or from a plain product operator, chosen by a parameter.

Top module: `fpmul_sp`

## Requirements
- R1: A word sampled with `in_valid` high at rising edge k produces `out_valid` high, with its result on `out_result`, after rising edge k+2. A cycle with `in_valid` low produces `out_valid` low two edges later. Under reset, `out_valid` and `out_result` are 0.
- R2: For every result that is not NaN, the sign bit (MSB) is the XOR of the two operand sign bits. This includes zero and infinite results.
- R3: For two normal operands, the result exponent field is ea + eb - bias, where bias = 2^(EXP_W-1) - 1. One more is added when the significand product is 2 or greater, in which case the product is shifted right by one. For example, 0x40000000 x 0x40400000 = 0x40C00000.
- R4: The rounding step keeps FRAC_W fraction bits. It rounds up when the discarded part is more than half an ulp. When the discarded part is exactly half an ulp, it rounds to the value whose fraction LSB is 0. Examples: 0x3F800001 x 0x3FC00000 = 0x3FC00002, and 0x3F800003 x 0x3FC00000 = 0x3FC00004.
- R5: When rounding carries out of the significand, the fraction becomes all zeros and the exponent goes up by one.
- R6: If either operand is NaN (exponent all ones, fraction nonzero), or the operation is zero times infinity, the result is the quiet NaN. That is sign 0, exponent all ones, and only the fraction MSB set: 0x7FC00000 in binary32, 0x7C in the 4/3 format.
- R7: Infinity (exponent all ones, fraction zero) times a nonzero finite value or infinity gives a signed infinity. A biased exponent of all ones or more after rounding also gives a signed infinity.
- R8: An operand with exponent field 0 counts as zero, so subnormals are flushed. Zero times a finite value gives a signed zero. A biased exponent of 0 or less after rounding also gives a signed zero. No subnormal is ever produced.
- R9: The radix-4 recoded and plain significand multipliers produce identical results for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on in_a/in_b are valid this cycle |
| in_a | input | 1+EXP_W+FRAC_W | First operand |
| in_b | input | 1+EXP_W+FRAC_W | Second operand |
| out_valid | output | 1 | out_result holds a product |
| out_result | output | 1+EXP_W+FRAC_W | Rounded product |

## Verification
Every product is due exactly two rising edges after its operands are sampled. Inputs are driven on falling edges, so the result of operands driven at falling edge n is read at falling edge n+2. The one-cycle-old window (falling edge n+1) is checked to show `out_valid` still low after an idle cycle. During the back-to-back sweep, the bench keeps a two-deep history of driven operands, so each output is compared with the pair that went in two cycles earlier. After the sweep, a bubble checks that `out_valid` drops two edges after `in_valid` does.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    // Operand classification after field extraction.
    typedef enum logic [1:0] {
        OPC_ZERO = 2'd0,
        OPC_NORM = 2'd1,
        OPC_INF  = 2'd2,
        OPC_NAN  = 2'd3
    } opc_e;

    // Special-case outcome decided in the first stage.
    typedef enum logic [1:0] {
        SPC_NONE = 2'd0,
        SPC_NAN  = 2'd1,
        SPC_INF  = 2'd2,
        SPC_ZERO = 2'd3
    } spc_e;

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1
) (
    input  logic [WORD_W-1:0] word,
    output logic              sgn,
    output logic [EXP_W-1:0]  bexp,
    output logic [SIG_W-1:0]  sig,
    output opc_e              cls
);

    logic [FRAC_W-1:0] frac;
    logic              exp_all1;
    logic              exp_all0;

    always_comb begin
        sgn      = word[WORD_W-1];
        bexp     = word[FRAC_W +: EXP_W];
        frac     = word[FRAC_W-1:0];
        exp_all1 = &bexp;
        exp_all0 = ~|bexp;
        // hidden bit restored; zero-class operands are overridden later
        sig      = {1'b1, frac};
        if (exp_all1) begin
            cls = (|frac) ? OPC_NAN : OPC_INF;
        end else if (exp_all0) begin
            cls = OPC_ZERO;          // subnormals flushed
        end else begin
            cls = OPC_NORM;
        end
    end

endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul #(
    parameter int SIG_W     = 24,
    parameter bit USE_BOOTH = 1'b1,
    localparam int PROD_W   = 2 * SIG_W
) (
    input  logic [SIG_W-1:0]  sig_a,
    input  logic [SIG_W-1:0]  sig_b,
    output logic [PROD_W-1:0] prod
);

    generate
        if (USE_BOOTH) begin : g_booth
            // radix-4 recoding of an unsigned multiplier: enough groups so
            // the top group's high bit is a padding zero
            localparam int GRP_N = SIG_W / 2 + 1;
            localparam int BZ_W  = 2 * GRP_N + 1;

            logic [BZ_W-1:0]   bz;
            logic [2:0]        trip;
            logic              neg;
            logic [PROD_W-1:0] mag;
            logic [PROD_W-1:0] row;
            logic [PROD_W-1:0] acc;

            assign bz = {{(BZ_W - SIG_W - 1){1'b0}}, sig_b, 1'b0};

            always_comb begin
                acc  = '0;
                trip = '0;
                neg  = 1'b0;
                mag  = '0;
                row  = '0;
                for (int g = 0; g < GRP_N; g++) begin
                    trip = bz[2*g +: 3];
                    neg  = trip[2] & ~(trip[1] & trip[0]);
                    unique case (trip)
                        3'b001, 3'b010, 3'b101, 3'b110: mag = PROD_W'(sig_a);
                        3'b011, 3'b100:                 mag = PROD_W'(sig_a) << 1;
                        default:                        mag = '0;
                    endcase
                    row = neg ? (~mag + PROD_W'(1)) : mag;
                    acc = acc + (row << (2 * g));
                end
            end

            assign prod = acc;
        end else begin : g_plain
            assign prod = PROD_W'(sig_a) * PROD_W'(sig_b);
        end
    endgenerate

endmodule

// File: rtl/fpm_round.sv
module fpm_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PROD_W = 2 * SIG_W,
    localparam int EW     = EXP_W + 3,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic                 sgn,
    input  logic signed [EW-1:0] exp_in,
    input  logic [PROD_W-1:0]    prod,
    output logic [WORD_W-1:0]    word,
    output logic                 lead
);

    localparam logic signed [EW-1:0] EXP_TOP  = EW'((1 << EXP_W) - 1);
    localparam logic signed [EW-1:0] EXP_ZERO = EW'(0);
    localparam logic signed [EW-1:0] EXP_ONE  = EW'(1);

    logic [PROD_W-1:0]    norm;
    logic [SIG_W-1:0]     mant;
    logic                 guard;
    logic                 sticky;
    logic                 up;
    logic [SIG_W:0]       mant_r;
    logic signed [EW-1:0] exp_n;
    logic signed [EW-1:0] exp_r;
    logic [FRAC_W-1:0]    frac_o;

    always_comb begin
        // product is 1x.xxx (top bit set) or 01.xxx
        norm   = prod[PROD_W-1] ? prod : (prod << 1);
        exp_n  = prod[PROD_W-1] ? (exp_in + EXP_ONE) : exp_in;
        mant   = norm[PROD_W-1 -: SIG_W];
        guard  = norm[FRAC_W];
        sticky = |norm[FRAC_W-1:0];
        up     = guard & (sticky | mant[0]);
        mant_r = {1'b0, mant} + {{SIG_W{1'b0}}, up};
        if (mant_r[SIG_W]) begin
            exp_r  = exp_n + EXP_ONE;
            frac_o = '0;
        end else begin
            exp_r  = exp_n;
            frac_o = mant_r[FRAC_W-1:0];
        end
        lead = mant_r[SIG_W] | mant_r[FRAC_W];
        if (exp_r >= EXP_TOP) begin
            word = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (exp_r <= EXP_ZERO) begin
            word = {sgn, {(WORD_W-1){1'b0}}};
        end else begin
            word = {sgn, exp_r[EXP_W-1:0], frac_o};
        end
    end

endmodule

// File: rtl/fpmul_sp.sv
module fpmul_sp
    import fpm_pkg::*;
#(
    parameter int EXP_W     = 8,
    parameter int FRAC_W    = 23,
    parameter bit USE_BOOTH = 1'b1,
    localparam int WORD_W   = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result
);

    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int EW     = EXP_W + 3;
    localparam logic signed [EW-1:0] BIAS_S = EW'((1 << (EXP_W - 1)) - 1);
    localparam logic [WORD_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic                 vld;
        logic                 sgn;
        spc_e                 spc;
        logic signed [EW-1:0] exp_sum;
        logic [PROD_W-1:0]    prod;
    } stg1_t;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] res;
    } stg2_t;

    stg1_t s1_d, s1_q;
    stg2_t s2_d, s2_q;

    logic              sgn_a, sgn_b;
    logic [EXP_W-1:0]  bexp_a, bexp_b;
    logic [SIG_W-1:0]  sig_a, sig_b;
    opc_e              cls_a, cls_b;
    logic [PROD_W-1:0] prod_w;
    logic [WORD_W-1:0] rnd_word;
    logic              rnd_lead;

    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
        .word(in_a), .sgn(sgn_a), .bexp(bexp_a), .sig(sig_a), .cls(cls_a)
    );

    fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
        .word(in_b), .sgn(sgn_b), .bexp(bexp_b), .sig(sig_b), .cls(cls_b)
    );

    fpm_sigmul #(.SIG_W(SIG_W), .USE_BOOTH(USE_BOOTH)) u_mul (
        .sig_a(sig_a), .sig_b(sig_b), .prod(prod_w)
    );

    fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
        .sgn(s1_q.sgn), .exp_in(s1_q.exp_sum), .prod(s1_q.prod),
        .word(rnd_word), .lead(rnd_lead)
    );

    // stage 1: classify, sum exponents, multiply significands
    always_comb begin
        s1_d.vld     = in_valid;
        s1_d.sgn     = sgn_a ^ sgn_b;
        s1_d.exp_sum = $signed({3'b000, bexp_a}) + $signed({3'b000, bexp_b}) - BIAS_S;
        s1_d.prod    = prod_w;
        if (cls_a == OPC_NAN || cls_b == OPC_NAN ||
            (cls_a == OPC_INF && cls_b == OPC_ZERO) ||
            (cls_a == OPC_ZERO && cls_b == OPC_INF)) begin
            s1_d.spc = SPC_NAN;
        end else if (cls_a == OPC_INF || cls_b == OPC_INF) begin
            s1_d.spc = SPC_INF;
        end else if (cls_a == OPC_ZERO || cls_b == OPC_ZERO) begin
            s1_d.spc = SPC_ZERO;
        end else begin
            s1_d.spc = SPC_NONE;
        end
    end

    // stage 2: normalize/round result or special value
    always_comb begin
        s2_d.vld = s1_q.vld;
        unique case (s1_q.spc)
            SPC_NAN:  s2_d.res = QNAN;
            SPC_INF:  s2_d.res = {s1_q.sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            SPC_ZERO: s2_d.res = {s1_q.sgn, {(WORD_W-1){1'b0}}};
            default:  s2_d.res = rnd_word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid  = s2_q.vld;
    assign out_result = s2_q.res;

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid) else $error("latency");            // R1
    AST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid) else $error("spurious valid");   // R1
    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !((&out_result[FRAC_W +: EXP_W]) && (|out_result[FRAC_W-1:0])))
        |-> out_result[WORD_W-1] == $past(in_a[WORD_W-1] ^ in_b[WORD_W-1], 2))
        else $error("sign");                                            // R2
    AST_QNAN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (&out_result[FRAC_W +: EXP_W]) && (|out_result[FRAC_W-1:0]))
        |-> out_result == QNAN) else $error("nan form");               // R6
    AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((|out_result[FRAC_W +: EXP_W]) || !(|out_result[FRAC_W-1:0])))
        else $error("subnormal out");                                   // R8
    AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.vld && s1_q.spc == SPC_NONE) |-> rnd_lead)
        else $error("lost leading one");                                // R5

endmodule

// File: tb/sim_fpmul_sp.sv
module sim_fpmul_sp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fv = 1'b0;
    logic [31:0] fa = '0, fb = '0;
    logic        f_ov;
    logic [31:0] f_res;
    logic        sv = 1'b0;
    logic [7:0]  sa = '0, sb = '0;
    logic        s1_ov, s2_ov;
    logic [7:0]  s1_res, s2_res;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fpmul_sp #(.EXP_W(8), .FRAC_W(23), .USE_BOOTH(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(fv), .in_a(fa), .in_b(fb),
        .out_valid(f_ov), .out_result(f_res));

    fpmul_sp #(.EXP_W(4), .FRAC_W(3), .USE_BOOTH(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(sv), .in_a(sa), .in_b(sb),
        .out_valid(s1_ov), .out_result(s1_res));

    fpmul_sp #(.EXP_W(4), .FRAC_W(3), .USE_BOOTH(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .in_valid(sv), .in_a(sa), .in_b(sb),
        .out_valid(s2_ov), .out_result(s2_res));

    // arithmetic reference for a format with ew exponent and fw fraction bits
    function automatic longint unsigned ref_mul(input int ew, input int fw,
            input longint unsigned a, input longint unsigned b, output string tag);
        longint unsigned one  = 64'd1;
        longint unsigned emax = (one << ew) - 1;
        longint unsigned fmsk = (one << fw) - 1;
        longint          bias = (longint'(1) << (ew - 1)) - 1;
        longint unsigned s, ea, eb, ma, mb, p, keep, rem, half;
        longint          e;
        int              sh;
        s  = ((a >> (ew + fw)) ^ (b >> (ew + fw))) & 1;
        ea = (a >> fw) & emax;  eb = (b >> fw) & emax;
        ma = a & fmsk;          mb = b & fmsk;
        if ((ea == emax && ma != 0) || (eb == emax && mb != 0) ||
            (ea == emax && eb == 0) || (ea == 0 && eb == emax)) begin
            tag = "R6";
            return (emax << fw) | (one << (fw - 1));
        end
        if (ea == emax || eb == emax) begin
            tag = "R7";
            return (s << (ew + fw)) | (emax << fw);
        end
        if (ea == 0 || eb == 0) begin
            tag = "R8";
            return s << (ew + fw);
        end
        p = ((one << fw) | ma) * ((one << fw) | mb);
        e = longint'(ea) + longint'(eb) - bias;
        if (((p >> (2 * fw + 1)) & 1) != 0) begin
            sh = fw + 1;
            e  = e + 1;
        end else begin
            sh = fw;
        end
        keep = p >> sh;
        rem  = p & ((one << sh) - 1);
        half = one << (sh - 1);
        tag  = (rem != 0) ? "R4" : "R3";
        if (rem > half || (rem == half && (keep & 1) != 0)) keep = keep + 1;
        if (keep == (one << (fw + 1))) begin
            keep = keep >> 1;
            e    = e + 1;
            tag  = "R5";
        end
        if (e >= longint'(emax)) begin
            tag = "R7";
            return (s << (ew + fw)) | (emax << fw);
        end
        if (e <= 0) begin
            tag = "R8";
            return s << (ew + fw);
        end
        return (s << (ew + fw)) | (longint'(e) << fw) | (keep & fmsk);
    endfunction

    task automatic report;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // directed binary32 case; result read two falling edges after driving
    task automatic chk32(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] want, input string tag);
        string rtag;
        longint unsigned r;
        @(negedge clk);
        fa = a; fb = b; fv = 1'b1;
        @(negedge clk);
        fv = 1'b0;
        checks++;
        if (f_ov !== 1'b0) begin
            fails++;
            $display("FAIL R1 early valid actual=%b expected=0", f_ov);
        end
        @(negedge clk);
        r = ref_mul(8, 23, 64'(a), 64'(b), rtag);
        checks++;
        if (f_ov !== 1'b1 || f_res !== want || 32'(r) !== want) begin
            fails++;
            $display("FAIL %s a=%h b=%h actual=%h/%b expected=%h (model %h)",
                     tag, a, b, f_res, f_ov, want, 32'(r));
        end
    endtask

    task automatic chk_small(input logic [7:0] a, input logic [7:0] b);
        string tag;
        logic [7:0] want;
        want = 8'(ref_mul(4, 3, 64'(a), 64'(b), tag));
        checks++;
        if (s1_ov !== 1'b1 || s1_res !== want) begin
            fails++;
            $display("FAIL %s a=%h b=%h actual=%h/%b expected=%h",
                     tag, a, b, s1_res, s1_ov, want);
        end
        checks++;
        if (s2_ov !== 1'b1 || s2_res !== s1_res) begin
            fails++;
            $display("FAIL R9 a=%h b=%h actual=%h expected=%h", a, b, s2_res, s1_res);
        end
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [7:0] ha [2];
        logic [7:0] hb [2];
        logic       hv [2];
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R1 reset state
        if (f_ov !== 1'b0 || f_res !== 32'h0 || s1_ov !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual=%b/%h expected=0/00000000", f_ov, f_res);
        end
        rst_n = 1'b1;

        chk32(32'h40000000, 32'h40400000, 32'h40C00000, "R3");
        chk32(32'h3FC00000, 32'h3FC00000, 32'h40100000, "R3");
        chk32(32'hBF400000, 32'h3F800000, 32'hBF400000, "R3");
        chk32(32'hBF400000, 32'h40000000, 32'hBFC00000, "R2");
        chk32(32'hC0000000, 32'hC0400000, 32'h40C00000, "R2");
        chk32(32'h3F800001, 32'h3FC00000, 32'h3FC00002, "R4");
        chk32(32'h3F800003, 32'h3FC00000, 32'h3FC00004, "R4");
        chk32(32'h3F800001, 32'h3F800001, 32'h3F800002, "R4");
        chk32(32'h7FC12345, 32'h3F800000, 32'h7FC00000, "R6");
        chk32(32'hFF800001, 32'h7F800000, 32'h7FC00000, "R6");
        chk32(32'h00000000, 32'hFF800000, 32'h7FC00000, "R6");
        chk32(32'h7F800000, 32'hC0000000, 32'hFF800000, "R7");
        chk32(32'h7F000000, 32'h7F000000, 32'h7F800000, "R7");
        chk32(32'h7F7FFFFF, 32'h3F800001, 32'h7F800000, "R7");
        chk32(32'h00800000, 32'h00800000, 32'h00000000, "R8");
        chk32(32'h80800000, 32'h3F000000, 32'h80000000, "R8");
        chk32(32'h00000001, 32'h3F800000, 32'h00000000, "R8");
        chk32(32'h80000005, 32'h40000000, 32'h80000000, "R8");

        // exhaustive sweep of the 4/3 format, one pair per cycle (R3..R9)
        hv[0] = 1'b0; hv[1] = 1'b0;
        ha[0] = '0; ha[1] = '0; hb[0] = '0; hb[1] = '0;
        for (int n = 0; n < 65536 + 2; n++) begin
            @(negedge clk);
            if (hv[1]) chk_small(ha[1], hb[1]);
            ha[1] = ha[0]; hb[1] = hb[0]; hv[1] = hv[0];
            if (n < 65536) begin
                sa = 8'(n >> 8); sb = 8'(n);
                sv = 1'b1;
                ha[0] = sa; hb[0] = sb; hv[0] = 1'b1;
            end else begin
                sv = 1'b0;
                hv[0] = 1'b0;
            end
        end
        // R1: bubble drains, valid low
        @(negedge clk);
        checks++;
        if (s1_ov !== 1'b0 || s2_ov !== 1'b0) begin
            fails++;
            $display("FAIL R1 drain actual=%b%b expected=00", s1_ov, s2_ov);
        end
        report();
    end

endmodule